// File: doc/BRIEF.md
# HDLC B-Channel Serial Transmitter

This block pulls octets from a show-ahead transmit FIFO and shifts them out one bit per enable strobe onto a 64 kbps B channel. It has two modes. In framed mode each FIFO run becomes an HDLC frame. The frame opens with a flag, then carries the data bits least significant bit first, with a zero inserted after every five consecutive ones. A complemented CRC-16 follows, and a closing flag ends the frame. In raw mode the octets leave exactly as stored. A 56 kbps option sets bit 7 of every FIFO octet before it is sent. A separate comparator raises a one-clock interrupt when the FIFO's free-space count first reaches the selected threshold.

The sequencer has seven states. IDLE sends the fill pattern and, at each octet boundary, chooses between OPEN when the FIFO has data in framed mode, RAW when it has data in raw mode, or staying in IDLE. OPEN sends the opening flag and then goes to DATA, or to ABORT if the FIFO is empty. DATA goes to CRC after the octet marked last. DATA goes to ABORT on an underrun. Otherwise DATA reloads itself. CRC goes to CLOSE after 16 check bits. CLOSE goes to IDLE and pulses frame-done. ABORT sends a run of ones and goes to IDLE. RAW reloads itself while the FIFO has data and otherwise returns to IDLE. Every state advances only on a strobe.

Top module: `hdlc_btx`

## Requirements
- R1: After reset `tx_bit` is 1, and `fifo_rd`, `frame_done`, `underrun` and `thr_irq` are 0.
- R2: When no octet is in progress, the line carries fill. With `cfg_fill_flag`=0 the fill is all ones. With `cfg_fill_flag`=1 in framed mode the fill is repeated flags, sent as the bit order 0,1,1,1,1,1,1,0. In raw mode the fill is always ones.
- R3: In framed mode a frame starts at the first fill-octet boundary that finds the FIFO non-empty. The frame is an opening flag, the data octets least significant bit first, the check sequence and a closing flag. The FIFO entry marked `fifo_last` ends the frame.
- R4: Across data and check bits, a 0 is inserted after any five consecutive ones. This also applies just before the closing flag. Flags are never stuffed.
- R5: The check sequence is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, taken over the data bits as sent before stuffing. It is complemented and sent low octet first, least significant bit first. For the data "123456789" the octets sent are 0x6E then 0x90.
- R6: In raw mode the FIFO octets are sent back to back, least significant bit first, with no flags, stuffing or CRC. The stream stops at the first octet boundary that finds the FIFO empty.
- R7: With `cfg_56k`=1, bit 7 of every FIFO octet is forced to 1 before it is sent and before it enters the CRC, in both modes.
- R8: If the FIFO is empty at an octet boundary inside a frame, before the last-marked entry, eight ones are sent in place of the rest of the frame. Then fill resumes, `underrun` pulses once and `frame_done` stays 0.
- R9: `frame_done` pulses for one clock after the last bit of the closing flag, and only then.
- R10: `thr_irq` pulses for one clock the cycle after `fifo_free` first reaches at least 64 (`cfg_thr_sel`=0) or at least 96 (`cfg_thr_sel`=1). It re-arms only once `fifo_free` falls below the threshold.
- R11: `tx_bit` changes only on a clock where `bit_en` is 1. `fifo_rd` is asserted only with `bit_en` and a non-empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_raw | input | 1 | 1 = raw mode, 0 = framed mode |
| cfg_fill_flag | input | 1 | Fill select: 0 ones, 1 flags |
| cfg_56k | input | 1 | Force bit 7 of every FIFO octet to 1 |
| cfg_thr_sel | input | 1 | Free-space threshold: 0 = 64, 1 = 96 |
| fifo_data | input | 8 | Head octet of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head octet ends the frame |
| fifo_empty | input | 1 | FIFO holds no octet |
| fifo_free | input | FREE_W | Free entries in the FIFO |
| fifo_rd | output | 1 | Pop the head octet at this clock edge |
| bit_en | input | 1 | Bit strobe: one line bit per pulse |
| tx_bit | output | 1 | Serial line bit |
| frame_done | output | 1 | One-clock pulse after a closing flag |
| underrun | output | 1 | One-clock pulse when a frame is aborted |
| thr_irq | output | 1 | One-clock free-space threshold pulse |

## Verification
`tx_bit` takes each new line bit on the edge that samples `bit_en`, so the bench samples it at the falling edge after every strobe. It compares the sample against a bit stream built arithmetically from the octets, the stuffing rule and the CRC polynomial. The opening fill is always exactly eight bits long because every stream starts from reset. `fifo_rd` is combinational with the strobe, and the bench FIFO pops on that same edge. `frame_done` and `underrun` are registered one clock after the strobe that ends the flag or the octet, and the bench counts them on every rising edge. `thr_irq` is due one clock after `fifo_free` changes. The bench sweeps `fifo_free` upward, downward and upward again, one value per clock for both thresholds, and checks the pulse on the following falling edge.

// File: rtl/hdlc_btx_pkg.sv
package hdlc_btx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_DATA,
        S_CRC,
        S_CLOSE,
        S_ABORT,
        S_RAW
    } tx_state_e;

    localparam logic [7:0] FLAG_PAT = 8'h7E;
endpackage

// File: rtl/hdlc_btx_crc.sv
module hdlc_btx_crc #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8408
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    // One reflected shift step of the check register
    always_comb begin
        crc_o = crc_i >> 1;
        if (crc_i[0] ^ bit_i) crc_o = crc_o ^ POLY;
    end
endmodule

// File: rtl/hdlc_btx_thr.sv
module hdlc_btx_thr #(
    parameter int FREE_W = 8,
    parameter int THR_LO = 64,
    parameter int THR_HI = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [FREE_W-1:0] free_cnt,
    output logic              irq
);
    logic meet, meet_q;

    assign meet = free_cnt >= (sel ? FREE_W'(THR_HI) : FREE_W'(THR_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meet_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            meet_q <= meet;
            irq    <= meet && !meet_q;
        end
    end

    // R10: the interrupt is a single-clock pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/hdlc_btx.sv
module hdlc_btx
    import hdlc_btx_pkg::*;
#(
    parameter int FREE_W     = 8,
    parameter int THR_LO     = 64,
    parameter int THR_HI     = 96,
    parameter int ABORT_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_raw,
    input  logic              cfg_fill_flag,
    input  logic              cfg_56k,
    input  logic              cfg_thr_sel,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_last,
    input  logic              fifo_empty,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_rd,
    input  logic              bit_en,
    output logic              tx_bit,
    output logic              frame_done,
    output logic              underrun
    ,output logic             thr_irq
);
    localparam int CNT_W  = 4;
    localparam int CRC_W  = 16;
    localparam logic [CNT_W-1:0] ABORT_END = CNT_W'(ABORT_BITS - 1);
    localparam logic [CNT_W-1:0] CRC_END   = CNT_W'(CRC_W - 1);

    tx_state_e         state_q, state_d;
    logic [CRC_W-1:0]  sh_q, sh_d;
    logic [CRC_W-1:0]  crc_q, crc_d, crc_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [2:0]        ones_q, ones_d;
    logic              last_q, last_d;
    logic              tx_d, done_d, urun_d, rd;
    logic              stuff_now, octet_end;
    logic [7:0]        byte_in;

    assign byte_in   = fifo_data | (cfg_56k ? 8'h80 : 8'h00);
    assign stuff_now = (state_q == S_DATA || state_q == S_CRC || state_q == S_CLOSE)
                       && ones_q == 3'd5;
    assign octet_end = cnt_q[2:0] == 3'd7;
    assign fifo_rd   = rd;

    hdlc_btx_crc #(.W(CRC_W), .POLY(16'h8408)) u_crc (
        .crc_i (crc_q),
        .bit_i (sh_q[0]),
        .crc_o (crc_nx)
    );

    hdlc_btx_thr #(.FREE_W(FREE_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (cfg_thr_sel),
        .free_cnt (fifo_free),
        .irq      (thr_irq)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sh_q    <= '0;
            crc_q   <= '1;
            cnt_q   <= '0;
            ones_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            crc_q   <= crc_d;
            cnt_q   <= cnt_d;
            ones_q  <= ones_d;
            last_q  <= last_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit     <= 1'b1;
            frame_done <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            tx_bit     <= tx_d;
            frame_done <= done_d;
            underrun   <= urun_d;
        end
    end

    // Next state and line bit
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        crc_d   = crc_q;
        cnt_d   = cnt_q;
        ones_d  = ones_q;
        last_d  = last_q;
        tx_d    = tx_bit;
        done_d  = 1'b0;
        urun_d  = 1'b0;
        rd      = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                S_IDLE: begin
                    tx_d  = (cfg_fill_flag && !cfg_raw) ? FLAG_PAT[cnt_q[2:0]] : 1'b1;
                    cnt_d = {1'b0, cnt_q[2:0] + 3'd1};
                    if (octet_end && !fifo_empty) begin
                        cnt_d = '0;
                        if (cfg_raw) begin
                            rd      = 1'b1;
                            sh_d    = {8'h00, byte_in};
                            state_d = S_RAW;
                        end else begin
                            state_d = S_OPEN;
                        end
                    end
                end
                S_OPEN: begin
                    tx_d  = FLAG_PAT[cnt_q[2:0]];
                    cnt_d = cnt_q + 1'b1;
                    if (octet_end) begin
                        cnt_d  = '0;
                        crc_d  = '1;
                        ones_d = '0;
                        if (fifo_empty) begin
                            state_d = S_ABORT;
                            urun_d  = 1'b1;
                        end else begin
                            rd      = 1'b1;
                            sh_d    = {8'h00, byte_in};
                            last_d  = fifo_last;
                            state_d = S_DATA;
                        end
                    end
                end
                S_DATA: begin
                    if (stuff_now) begin
                        tx_d   = 1'b0;
                        ones_d = '0;
                    end else begin
                        tx_d   = sh_q[0];
                        ones_d = sh_q[0] ? ones_q + 3'd1 : 3'd0;
                        crc_d  = crc_nx;
                        sh_d   = sh_q >> 1;
                        cnt_d  = cnt_q + 1'b1;
                        if (octet_end) begin
                            cnt_d = '0;
                            if (last_q) begin
                                sh_d    = ~crc_nx;
                                state_d = S_CRC;
                            end else if (fifo_empty) begin
                                state_d = S_ABORT;
                                urun_d  = 1'b1;
                            end else begin
                                rd     = 1'b1;
                                sh_d   = {8'h00, byte_in};
                                last_d = fifo_last;
                            end
                        end
                    end
                end
                S_CRC: begin
                    if (stuff_now) begin
                        tx_d   = 1'b0;
                        ones_d = '0;
                    end else begin
                        tx_d   = sh_q[0];
                        ones_d = sh_q[0] ? ones_q + 3'd1 : 3'd0;
                        sh_d   = sh_q >> 1;
                        cnt_d  = cnt_q + 1'b1;
                        if (cnt_q == CRC_END) begin
                            cnt_d   = '0;
                            state_d = S_CLOSE;
                        end
                    end
                end
                S_CLOSE: begin
                    ones_d = '0;
                    if (stuff_now) begin
                        tx_d = 1'b0;
                    end else begin
                        tx_d  = FLAG_PAT[cnt_q[2:0]];
                        cnt_d = cnt_q + 1'b1;
                        if (octet_end) begin
                            cnt_d   = '0;
                            done_d  = 1'b1;
                            state_d = S_IDLE;
                        end
                    end
                end
                S_ABORT: begin
                    tx_d   = 1'b1;
                    ones_d = '0;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == ABORT_END) begin
                        cnt_d   = '0;
                        state_d = S_IDLE;
                    end
                end
                S_RAW: begin
                    tx_d  = sh_q[0];
                    sh_d  = sh_q >> 1;
                    cnt_d = cnt_q + 1'b1;
                    if (octet_end) begin
                        cnt_d = '0;
                        if (!fifo_empty) begin
                            rd   = 1'b1;
                            sh_d = {8'h00, byte_in};
                        end else begin
                            state_d = S_IDLE;
                        end
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // R11: pops only on a strobe and never from an empty FIFO
    p_rd_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (bit_en && !fifo_empty));
    // R11: line bit holds between strobes
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R4: a sixth data one is never sent
    p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state_q == S_DATA && ones_q == 3'd5) |=> !tx_bit);
    // R8: an aborted frame never reports completion
    p_done_urun_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && underrun));
    // R9: completion only follows the closing flag
    p_done_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> $past(state_q) == S_CLOSE);
endmodule

// File: tb/hdlc_btx_tb.sv
module hdlc_btx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_raw = 1'b0, cfg_fill_flag = 1'b0, cfg_56k = 1'b0, cfg_thr_sel = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_last, fifo_empty, fifo_rd;
    logic [7:0] fifo_free = 8'd0;
    logic       bit_en = 1'b0;
    logic       tx_bit, frame_done, underrun, thr_irq;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    // Bench FIFO, show-ahead
    logic [7:0] mem_d [0:63];
    logic       mem_l [0:63];
    int wr_cnt = 0, rd_ptr = 0;
    assign fifo_empty = (rd_ptr == wr_cnt);
    assign fifo_data  = mem_d[rd_ptr % 64];
    assign fifo_last  = mem_l[rd_ptr % 64];

    int done_cnt = 0, urun_cnt = 0, bad_rd = 0;
    always @(posedge clk) begin
        if (fifo_rd) rd_ptr <= rd_ptr + 1;
        if (frame_done) done_cnt <= done_cnt + 1;
        if (underrun) urun_cnt <= urun_cnt + 1;
        if (fifo_rd && !bit_en) bad_rd <= bad_rd + 1;
    end

    hdlc_btx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_raw), .cfg_fill_flag(cfg_fill_flag),
        .cfg_56k(cfg_56k), .cfg_thr_sel(cfg_thr_sel), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_empty(fifo_empty), .fifo_free(fifo_free),
        .fifo_rd(fifo_rd), .bit_en(bit_en), .tx_bit(tx_bit), .frame_done(frame_done),
        .underrun(underrun), .thr_irq(thr_irq)
    );

    // Expected stream
    logic exp_b [0:1023];
    int   exp_n;
    int   ones_run;
    logic [7:0] fdat [0:15];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_stuffed(input logic b);
        push(b);
        ones_run = b ? ones_run + 1 : 0;
        if (ones_run == 5) begin
            push(1'b0);
            ones_run = 0;
        end
    endtask

    task automatic push_fill(input int n, input logic flags);
        for (int i = 0; i < n; i++) push(flags ? ((8'h7E >> (i % 8)) & 8'h01) != 0 : 1'b1);
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    // Framed stream: fixed_fcs < 0 means computed check value
    task automatic build_framed(input int n, input logic flags, input logic f56, input int fixed_fcs);
        logic [15:0] c, fcs;
        logic [7:0]  v;
        exp_n = 0; ones_run = 0; c = 16'hFFFF;
        push_fill(8, flags);
        push_fill(8, 1'b1 ? 1'b1 : 1'b0);
        exp_n = exp_n - 8;
        for (int i = 0; i < 8; i++) push(((8'h7E >> i) & 8'h01) != 0);
        for (int k = 0; k < n; k++) begin
            v = fdat[k] | (f56 ? 8'h80 : 8'h00);
            for (int i = 0; i < 8; i++) begin
                c = crc_bit(c, v[i]);
                push_stuffed(v[i]);
            end
        end
        fcs = (fixed_fcs < 0) ? ~c : 16'(fixed_fcs);
        for (int i = 0; i < 16; i++) push_stuffed(fcs[i]);
        for (int i = 0; i < 8; i++) push(((8'h7E >> i) & 8'h01) != 0);
        push_fill(16, flags);
    endtask

    task automatic load(input int n, input logic mark_last);
        for (int k = 0; k < n; k++) begin
            mem_d[wr_cnt % 64] = fdat[k];
            mem_l[wr_cnt % 64] = mark_last && (k == n - 1);
            wr_cnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_stream(input string req);
        int bad_at;
        logic got;
        bad_at = -1;
        got = 1'b0;
        for (int i = 0; i < exp_n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            if (bad_at < 0 && tx_bit !== exp_b[i]) begin
                bad_at = i;
                got = tx_bit;
            end
        end
        checks++;
        if (bad_at >= 0) begin
            fails++;
            $display("FAIL %s bit %0d actual=%0b expected=%0b", req, bad_at, got, exp_b[bad_at]);
        end
    endtask

    task automatic sweep(input int lo, input int hi, input int step, input int thr, input string req);
        int v;
        v = lo;
        while (1) begin
            @(negedge clk);
            fifo_free = 8'(v);
            @(negedge clk);
            check(req, {31'd0, thr_irq}, {31'd0, (step > 0 && v == thr)});
            if (v == hi) break;
            v = v + step;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int d0, u0;
        do_reset();
        // R1: reset state
        check("R1 tx_bit", {31'd0, tx_bit}, 32'd1);
        check("R1 pulses", {29'd0, frame_done, underrun, thr_irq}, 32'd0);
        check("R1 fifo_rd", {31'd0, fifo_rd}, 32'd0);

        // R3 R2: framed, ones fill
        fdat[0] = 8'h01; fdat[1] = 8'h02;
        load(2, 1'b1); build_framed(2, 1'b0, 1'b0, -1);
        d0 = done_cnt;
        run_stream("R3 framed ones fill");
        check("R9 one done pulse", 32'(done_cnt - d0), 32'd1);

        // R4 R2: heavy stuffing, flag fill
        do_reset(); cfg_fill_flag = 1'b1;
        fdat[0] = 8'hFF; fdat[1] = 8'hFF; fdat[2] = 8'h7E; fdat[3] = 8'hF8;
        load(4, 1'b1); build_framed(4, 1'b1, 1'b0, -1);
        d0 = done_cnt;
        run_stream("R4 stuffing with flag fill R2");
        check("R9 done after stuffed frame", 32'(done_cnt - d0), 32'd1);

        // R5: known check value
        do_reset(); cfg_fill_flag = 1'b0;
        for (int i = 0; i < 9; i++) fdat[i] = 8'h31 + 8'(i);
        load(9, 1'b1); build_framed(9, 1'b0, 1'b0, 16'h906E);
        run_stream("R5 crc 6E 90");

        // R7: 56k framed
        do_reset(); cfg_56k = 1'b1;
        fdat[0] = 8'h00; fdat[1] = 8'h12; fdat[2] = 8'h7F;
        load(3, 1'b1); build_framed(3, 1'b0, 1'b1, -1);
        run_stream("R7 56k framed");
        cfg_56k = 1'b0;

        // R6 R2: raw mode, flag fill ignored
        do_reset(); cfg_raw = 1'b1; cfg_fill_flag = 1'b1;
        fdat[0] = 8'hA5; fdat[1] = 8'hFF; fdat[2] = 8'h3C; fdat[3] = 8'h00;
        load(4, 1'b0);
        exp_n = 0; push_fill(8, 1'b0);
        for (int k = 0; k < 4; k++) for (int i = 0; i < 8; i++) push(fdat[k][i]);
        push_fill(16, 1'b0);
        d0 = done_cnt;
        run_stream("R6 raw unchanged R2 ones");
        check("R6 no done in raw", 32'(done_cnt - d0), 32'd0);

        // R7: raw 56k
        do_reset(); cfg_56k = 1'b1; cfg_fill_flag = 1'b0;
        fdat[0] = 8'h00; fdat[1] = 8'h7F;
        load(2, 1'b0);
        exp_n = 0; push_fill(8, 1'b0);
        for (int k = 0; k < 2; k++) for (int i = 0; i < 8; i++) push((fdat[k] | 8'h80) >> i);
        push_fill(16, 1'b0);
        run_stream("R7 raw 56k");
        cfg_56k = 1'b0; cfg_raw = 1'b0;

        // R8: underrun
        do_reset(); cfg_fill_flag = 1'b1;
        fdat[0] = 8'h0F; fdat[1] = 8'h00;
        load(2, 1'b0);
        exp_n = 0; ones_run = 0; push_fill(8, 1'b1);
        for (int i = 0; i < 8; i++) push(((8'h7E >> i) & 8'h01) != 0);
        for (int k = 0; k < 2; k++) for (int i = 0; i < 8; i++) push_stuffed(fdat[k][i]);
        for (int i = 0; i < 8; i++) push(1'b1);
        push_fill(16, 1'b1);
        d0 = done_cnt; u0 = urun_cnt;
        run_stream("R8 abort stream");
        check("R8 underrun pulse", 32'(urun_cnt - u0), 32'd1);
        check("R8 no done", 32'(done_cnt - d0), 32'd0);
        check("R11 pops only on strobe", 32'(bad_rd), 32'd0);
        check("R11 fifo drained", 32'(wr_cnt - rd_ptr), 32'd0);

        // R10: threshold sweeps
        cfg_thr_sel = 1'b0;
        sweep(0, 200, 1, 64, "R10 rise 64");
        sweep(200, 0, -1, 64, "R10 fall 64");
        sweep(0, 200, 1, 64, "R10 rearm 64");
        cfg_thr_sel = 1'b1;
        sweep(200, 0, -1, 96, "R10 fall 96");
        sweep(0, 255, 1, 96, "R10 rise 96");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule